// File: doc/BRIEF.md
# Early-Wakeup Issue Queue for Single-Cycle ALU Operations

This block is a small centralized scheduling window. It sits between a dispatch stage and a single one-cycle integer ALU. Each slot holds one operation: an opcode, a destination tag, and two source operands. Each operand carries a tag, a ready flag and a value. Every cycle the block picks the oldest slot whose operands are both ready, sends that slot's operands to the ALU, and frees the slot.

The block broadcasts the chosen slot's destination tag in the cycle it is picked, rather than after the ALU produces the result. Waiting slots that match this early tag become ready at the next edge. Because the ALU takes one cycle, the producer's result sits on the ALU output register exactly when such a consumer is first allowed to issue. A bypass flag per operand steers that output into the ALU input in that case. A dependent chain therefore issues on back-to-back cycles with no bubble. Values made by other units arrive on a separate broadcast port, which carries a tag and its data together.

Top module: `early_wake_iq`

## Requirements
- R1: After reset the queue is empty: `issueValid`, `aluValid` and `full` are all low.
- R2: A dispatch is written only when `dispValid` is high and `full` is low. A dispatch offered while `full` is high is dropped, and that operation never issues.
- R3: In each cycle at most one slot issues. The issued slot is the oldest in dispatch order among the slots whose two operands are ready. Its destination tag appears on `issueDstTag` in that same cycle.
- R4: An operation issued in cycle t shows `aluValid` high in cycle t+1, with `aluTag` equal to its destination tag. The result follows the opcode: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a XOR b, modulo 2^32, with a from source A and b from source B.
- R5: When the last pending operand of a waiting slot matches the tag issued in cycle t, that slot can issue in cycle t+1. A chain of dependent one-cycle operations therefore issues on consecutive cycles.
- R6: An operand woken by an issue tag uses the ALU output as its value when its slot issues in the next cycle. If the slot is not chosen in that cycle, it keeps that ALU output as the operand value for later.
- R7: While `extValid` is high, every waiting operand whose tag equals `extTag` takes `extVal` and becomes ready. Its slot can issue in the following cycle. The external match wins when both broadcasts carry the same tag.
- R8: A source dispatched without its ready flag, whose tag equals the external tag or the issue tag of the same cycle, enters the queue already ready: with `extVal` in the first case, or with the bypass in the second.
- R9: `full` is high exactly when every slot holds an operation. A slot becomes free at the edge that ends the cycle in which it issues.
- R10: Each issue removes exactly one slot, so with no dispatch accepted the occupancy drops by one per issuing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispOp | input | 2 | Opcode (0 add, 1 sub, 2 and, 3 xor) |
| dispSrcATag | input | 6 | Source A tag |
| dispSrcAReady | input | 1 | Source A value already valid |
| dispSrcAVal | input | 32 | Source A value |
| dispSrcBTag | input | 6 | Source B tag |
| dispSrcBReady | input | 1 | Source B value already valid |
| dispSrcBVal | input | 32 | Source B value |
| dispDstTag | input | 6 | Destination tag |
| full | output | 1 | No free slot; dispatch is dropped |
| extValid | input | 1 | External result broadcast valid |
| extTag | input | 6 | External result tag |
| extVal | input | 32 | External result value |
| issueValid | output | 1 | A slot issues this cycle |
| issueDstTag | output | 6 | Early broadcast tag of the issuing slot |
| aluValid | output | 1 | ALU result valid |
| aluTag | output | 6 | Tag of the ALU result |
| aluResult | output | 32 | ALU result value |

## Verification
Issue outputs are combinational from the slot state, so a slot made ready at an edge (by dispatch, external broadcast or early wakeup) is due on `issueValid`/`issueDstTag` in the very next cycle, and its value appears on `aluResult` one edge later. `full` reflects the occupancy after the last edge, so it drops one cycle after the issuing cycle. The bench drives inputs just after the falling edge. It then steps a behavioural model of these latencies one cycle at a time and compares every output in the middle of the low phase, so each expectation is tied to the exact cycle it is due. Directed scenarios then check the issue cycles and results of a three-deep chain, contended oldest-first selection, same-cycle dispatch capture, and a full queue.

// File: rtl/iq_pkg.sv
package iqPkg;

  localparam int IQ_ENTRIES = 8;
  localparam int IQ_TAG_W   = 6;
  localparam int IQ_DATA_W  = 32;
  localparam int IQ_OP_W    = 2;

  typedef enum logic [IQ_OP_W-1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } aluOp_e;

  // strobes handed from the tag/select control to the value datapath
  typedef struct packed {
    logic [IQ_ENTRIES-1:0] dispOh;   // slot written by dispatch
    logic [IQ_ENTRIES-1:0] grantOh;  // slot issuing this cycle
    logic [IQ_ENTRIES-1:0] extCapA;  // operand A takes external value
    logic [IQ_ENTRIES-1:0] extCapB;
    logic [IQ_ENTRIES-1:0] fwdCapA;  // operand A takes ALU output
    logic [IQ_ENTRIES-1:0] fwdCapB;
    logic                  dispAExt; // dispatched A comes from extVal
    logic                  dispBExt;
    logic                  useFwdA;  // issuing A comes from ALU output
    logic                  useFwdB;
    logic                  issue;
  } iqStrobe_t;

endpackage

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iqPkg::*;
#(
  parameter  int TAG_W   = IQ_TAG_W,
  localparam int ENTRIES = IQ_ENTRIES,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dispValid,
  input  logic [TAG_W-1:0]   dispSrcATag,
  input  logic               dispSrcAReady,
  input  logic [TAG_W-1:0]   dispSrcBTag,
  input  logic               dispSrcBReady,
  input  logic [TAG_W-1:0]   dispDstTag,
  input  logic               extValid,
  input  logic [TAG_W-1:0]   extTag,
  output logic               full,
  output logic               issueValid,
  output logic [IDX_W-1:0]   issueIdx,
  output logic [TAG_W-1:0]   issueDstTag,
  output logic [ENTRIES-1:0] busyVec,
  output iqStrobe_t          strobe
);

  // slot state held on the tag side
  logic [ENTRIES-1:0] busyQ, rdyAQ, rdyBQ, fwdAQ, fwdBQ;
  logic [TAG_W-1:0]   tagAQ [ENTRIES];
  logic [TAG_W-1:0]   tagBQ [ENTRIES];
  logic [TAG_W-1:0]   dstQ  [ENTRIES];
  // olderQ[j][i] set: slot j was dispatched before slot i
  logic [ENTRIES-1:0] olderQ [ENTRIES];

  logic [ENTRIES-1:0] entryReady, grantVec;
  logic [ENTRIES-1:0] extHitA, extHitB, earlyHitA, earlyHitB;
  logic               dispAcc;
  logic [IDX_W-1:0]   dispIdx;
  logic               dispAExt, dispBExt, dispAEarly, dispBEarly;

  assign entryReady = busyQ & rdyAQ & rdyBQ;

  // wakeup match and oldest-first select, one lane per slot
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
    logic [ENTRIES-1:0] olderThan;
    always_comb begin
      for (int j = 0; j < ENTRIES; j++) olderThan[j] = olderQ[j][gi];
    end
    assign grantVec[gi]  = entryReady[gi] & ~|(entryReady & olderThan);
    assign extHitA[gi]   = busyQ[gi] & ~rdyAQ[gi] & extValid & (tagAQ[gi] == extTag);
    assign extHitB[gi]   = busyQ[gi] & ~rdyBQ[gi] & extValid & (tagBQ[gi] == extTag);
    assign earlyHitA[gi] = busyQ[gi] & ~rdyAQ[gi] & issueValid & ~extHitA[gi]
                         & (tagAQ[gi] == issueDstTag);
    assign earlyHitB[gi] = busyQ[gi] & ~rdyBQ[gi] & issueValid & ~extHitB[gi]
                         & (tagBQ[gi] == issueDstTag);
  end

  always_comb begin
    issueIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grantVec[i]) issueIdx = IDX_W'(i);
    end
  end

  assign issueValid  = |grantVec;
  assign issueDstTag = dstQ[issueIdx];

  // lowest free slot takes the dispatch
  always_comb begin
    dispIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busyQ[i]) dispIdx = IDX_W'(i);
    end
  end

  assign full    = &busyQ;
  assign busyVec = busyQ;
  assign dispAcc = dispValid & ~full;

  assign dispAExt   = extValid & ~dispSrcAReady & (dispSrcATag == extTag);
  assign dispBExt   = extValid & ~dispSrcBReady & (dispSrcBTag == extTag);
  assign dispAEarly = issueValid & ~dispSrcAReady & ~dispAExt & (dispSrcATag == issueDstTag);
  assign dispBEarly = issueValid & ~dispSrcBReady & ~dispBExt & (dispSrcBTag == issueDstTag);

  always_comb begin
    strobe          = '0;
    if (dispAcc) strobe.dispOh[dispIdx] = 1'b1;
    strobe.grantOh  = grantVec;
    strobe.extCapA  = extHitA;
    strobe.extCapB  = extHitB;
    strobe.fwdCapA  = busyQ & fwdAQ;
    strobe.fwdCapB  = busyQ & fwdBQ;
    strobe.dispAExt = dispAExt;
    strobe.dispBExt = dispBExt;
    strobe.useFwdA  = issueValid & fwdAQ[issueIdx];
    strobe.useFwdB  = issueValid & fwdBQ[issueIdx];
    strobe.issue    = issueValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= '0;
      rdyAQ <= '0;
      rdyBQ <= '0;
      fwdAQ <= '0;
      fwdBQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagAQ[i]  <= '0;
        tagBQ[i]  <= '0;
        dstQ[i]   <= '0;
        olderQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (dispAcc && dispIdx == IDX_W'(i)) begin
          busyQ[i] <= 1'b1;
          tagAQ[i] <= dispSrcATag;
          tagBQ[i] <= dispSrcBTag;
          dstQ[i]  <= dispDstTag;
          rdyAQ[i] <= dispSrcAReady | dispAExt | dispAEarly;
          rdyBQ[i] <= dispSrcBReady | dispBExt | dispBEarly;
          fwdAQ[i] <= dispAEarly;
          fwdBQ[i] <= dispBEarly;
        end else begin
          if (grantVec[i]) busyQ[i] <= 1'b0;
          // bypass flag lives one cycle: value is captured at this edge
          if (fwdAQ[i]) fwdAQ[i] <= 1'b0;
          if (fwdBQ[i]) fwdBQ[i] <= 1'b0;
          if (extHitA[i]) rdyAQ[i] <= 1'b1;
          if (extHitB[i]) rdyBQ[i] <= 1'b1;
          if (earlyHitA[i]) begin
            rdyAQ[i] <= 1'b1;
            fwdAQ[i] <= 1'b1;
          end
          if (earlyHitB[i]) begin
            rdyBQ[i] <= 1'b1;
            fwdBQ[i] <= 1'b1;
          end
        end
        for (int j = 0; j < ENTRIES; j++) begin
          if (dispAcc) begin
            if (dispIdx == IDX_W'(j))      olderQ[i][j] <= busyQ[i];
            else if (dispIdx == IDX_W'(i)) olderQ[i][j] <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/iq_data.sv
module iq_data
  import iqPkg::*;
#(
  parameter  int TAG_W   = IQ_TAG_W,
  parameter  int DATA_W  = IQ_DATA_W,
  localparam int ENTRIES = IQ_ENTRIES,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  iqStrobe_t         strobe,
  input  logic [IDX_W-1:0]  issueIdx,
  input  logic [TAG_W-1:0]  issueDstTag,
  input  logic [IQ_OP_W-1:0] dispOp,
  input  logic [DATA_W-1:0] dispSrcAVal,
  input  logic [DATA_W-1:0] dispSrcBVal,
  input  logic [DATA_W-1:0] extVal,
  output logic              aluValid,
  output logic [TAG_W-1:0]  aluTag,
  output logic [DATA_W-1:0] aluResult
);

  aluOp_e            opQ   [ENTRIES];
  logic [DATA_W-1:0] valAQ [ENTRIES];
  logic [DATA_W-1:0] valBQ [ENTRIES];

  logic [DATA_W-1:0] opndA, opndB, aluNext;

  // operand select with bypass from the ALU output register
  assign opndA = strobe.useFwdA ? aluResult : valAQ[issueIdx];
  assign opndB = strobe.useFwdB ? aluResult : valBQ[issueIdx];

  always_comb begin
    unique case (opQ[issueIdx])
      OP_ADD:  aluNext = opndA + opndB;
      OP_SUB:  aluNext = opndA - opndB;
      OP_AND:  aluNext = opndA & opndB;
      OP_XOR:  aluNext = opndA ^ opndB;
      default: aluNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aluValid  <= 1'b0;
      aluTag    <= '0;
      aluResult <= '0;
    end else begin
      aluValid <= strobe.issue;
      if (strobe.issue) begin
        aluTag    <= issueDstTag;
        aluResult <= aluNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        opQ[i]   <= OP_ADD;
        valAQ[i] <= '0;
        valBQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.dispOh[i]) begin
          opQ[i]   <= aluOp_e'(dispOp);
          valAQ[i] <= strobe.dispAExt ? extVal : dispSrcAVal;
          valBQ[i] <= strobe.dispBExt ? extVal : dispSrcBVal;
        end else begin
          if (strobe.extCapA[i])      valAQ[i] <= extVal;
          else if (strobe.fwdCapA[i]) valAQ[i] <= aluResult;
          if (strobe.extCapB[i])      valBQ[i] <= extVal;
          else if (strobe.fwdCapB[i]) valBQ[i] <= aluResult;
        end
      end
    end
  end

endmodule

// File: rtl/early_wake_iq.sv
module early_wake_iq
  import iqPkg::*;
#(
  parameter  int TAG_W   = IQ_TAG_W,
  parameter  int DATA_W  = IQ_DATA_W,
  localparam int ENTRIES = IQ_ENTRIES,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dispValid,
  input  logic [IQ_OP_W-1:0] dispOp,
  input  logic [TAG_W-1:0]   dispSrcATag,
  input  logic               dispSrcAReady,
  input  logic [DATA_W-1:0]  dispSrcAVal,
  input  logic [TAG_W-1:0]   dispSrcBTag,
  input  logic               dispSrcBReady,
  input  logic [DATA_W-1:0]  dispSrcBVal,
  input  logic [TAG_W-1:0]   dispDstTag,
  output logic               full,
  input  logic               extValid,
  input  logic [TAG_W-1:0]   extTag,
  input  logic [DATA_W-1:0]  extVal,
  output logic               issueValid,
  output logic [TAG_W-1:0]   issueDstTag,
  output logic               aluValid,
  output logic [TAG_W-1:0]   aluTag,
  output logic [DATA_W-1:0]  aluResult
);

  iqStrobe_t          strobe;
  logic [IDX_W-1:0]   issueIdx;
  logic [ENTRIES-1:0] busyVec;

  iq_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .dispValid     (dispValid),
    .dispSrcATag   (dispSrcATag),
    .dispSrcAReady (dispSrcAReady),
    .dispSrcBTag   (dispSrcBTag),
    .dispSrcBReady (dispSrcBReady),
    .dispDstTag    (dispDstTag),
    .extValid      (extValid),
    .extTag        (extTag),
    .full          (full),
    .issueValid    (issueValid),
    .issueIdx      (issueIdx),
    .issueDstTag   (issueDstTag),
    .busyVec       (busyVec),
    .strobe        (strobe)
  );

  iq_data #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .issueIdx    (issueIdx),
    .issueDstTag (issueDstTag),
    .dispOp      (dispOp),
    .dispSrcAVal (dispSrcAVal),
    .dispSrcBVal (dispSrcBVal),
    .extVal      (extVal),
    .aluValid    (aluValid),
    .aluTag      (aluTag),
    .aluResult   (aluResult)
  );

endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int TAG_W   = 6,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dispValid,
  input logic               full,
  input logic               issueValid,
  input logic [TAG_W-1:0]   issueDstTag,
  input logic               aluValid,
  input logic [TAG_W-1:0]   aluTag,
  input logic [ENTRIES-1:0] busyVec,
  input logic [ENTRIES-1:0] grantVec
);

  AST_ALU_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |=> aluValid && aluTag == $past(issueDstTag)); // R4

  AST_ALU_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !issueValid |=> !aluValid); // R4

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec)); // R3

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !issueValid |=> full); // R2

  AST_DISPATCH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid && !full && !issueValid |=> $countones(busyVec) == $past($countones(busyVec)) + 1); // R2

  AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    full && issueValid |=> !full); // R9

  AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid && !(dispValid && !full) |=> $countones(busyVec) + 1 == $past($countones(busyVec))); // R10

endmodule

bind early_wake_iq iq_checker u_iqChecker (
  .clk         (clk),
  .rst_n       (rst_n),
  .dispValid   (dispValid),
  .full        (full),
  .issueValid  (issueValid),
  .issueDstTag (issueDstTag),
  .aluValid    (aluValid),
  .aluTag      (aluTag),
  .busyVec     (busyVec),
  .grantVec    (strobe.grantOh)
);

// File: tb/test_early_wake_iq.sv
`timescale 1ns/1ps
module test_early_wake_iq;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dispValid = 1'b0;
  logic [1:0]  dispOp = '0;
  logic [5:0]  dispSrcATag = '0, dispSrcBTag = '0, dispDstTag = '0;
  logic        dispSrcAReady = 1'b0, dispSrcBReady = 1'b0;
  logic [31:0] dispSrcAVal = '0, dispSrcBVal = '0;
  logic        extValid = 1'b0;
  logic [5:0]  extTag = '0;
  logic [31:0] extVal = '0;
  logic        full, issueValid, aluValid;
  logic [5:0]  issueDstTag, aluTag;
  logic [31:0] aluResult;

  early_wake_iq i_early_wake_iq (
    .clk(clk), .rst_n(rst_n),
    .dispValid(dispValid), .dispOp(dispOp),
    .dispSrcATag(dispSrcATag), .dispSrcAReady(dispSrcAReady), .dispSrcAVal(dispSrcAVal),
    .dispSrcBTag(dispSrcBTag), .dispSrcBReady(dispSrcBReady), .dispSrcBVal(dispSrcBVal),
    .dispDstTag(dispDstTag), .full(full),
    .extValid(extValid), .extTag(extTag), .extVal(extVal),
    .issueValid(issueValid), .issueDstTag(issueDstTag),
    .aluValid(aluValid), .aluTag(aluTag), .aluResult(aluResult)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int wdog = 0;

  // reference model: a pool of pending operations ordered by sequence number
  bit          mBusy [N];
  bit [1:0]    mOp [N];
  bit [5:0]    mTa [N], mTb [N], mDst [N];
  bit          mRa [N], mRb [N], mFa [N], mFb [N];
  bit [31:0]   mVa [N], mVb [N];
  int          mSeq [N];
  int          seqNext = 0;
  bit          mAluV = 0;
  bit [5:0]    mAluT = 0;
  bit [31:0]   mAluR = 0;

  int          issueCyc [64];
  bit [31:0]   resVal [64];

  task automatic chk(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=0", wdog);
      summary();
    end
  end

  function automatic bit [31:0] aluModel(bit [1:0] op, bit [31:0] a, bit [31:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic clearLog();
    for (int t = 0; t < 64; t++) begin
      issueCyc[t] = -1;
      resVal[t] = '0;
    end
  endtask

  // one clock: compare outputs with the model, then advance it
  task automatic step();
    int sel;
    int cnt;
    bit [31:0] res;
    bit [5:0] selDst;
    #1;
    sel = -1;
    cnt = 0;
    res = '0;
    selDst = '0;
    for (int k = 0; k < N; k++) begin
      if (mBusy[k]) cnt++;
      if (mBusy[k] && mRa[k] && mRb[k] && (sel < 0 || mSeq[k] < mSeq[sel])) sel = k;
    end
    chk(issueValid == (sel >= 0), "R3 issueValid", issueValid, sel >= 0);
    if (sel >= 0) chk(issueDstTag == mDst[sel], "R3 oldest tag", issueDstTag, mDst[sel]);
    chk(aluValid == mAluV, "R4 aluValid", aluValid, mAluV);
    if (mAluV) begin
      chk(aluTag == mAluT, "R4 aluTag", aluTag, mAluT);
      chk(aluResult == mAluR, "R4/R6 aluResult", aluResult, mAluR);
    end
    chk(full == (cnt == N), "R9 full", full, cnt == N);
    if (issueValid) issueCyc[issueDstTag] = cyc;
    if (aluValid) resVal[aluTag] = aluResult;

    if (sel >= 0) begin
      selDst = mDst[sel];
      res = aluModel(mOp[sel], mFa[sel] ? mAluR : mVa[sel], mFb[sel] ? mAluR : mVb[sel]);
    end
    for (int k = 0; k < N; k++) begin
      if (mBusy[k] && k != sel) begin
        if (mFa[k]) begin mVa[k] = mAluR; mFa[k] = 0; end
        else if (!mRa[k]) begin
          if (extValid && mTa[k] == extTag) begin mRa[k] = 1; mVa[k] = extVal; end
          else if (sel >= 0 && mTa[k] == selDst) begin mRa[k] = 1; mFa[k] = 1; end
        end
        if (mFb[k]) begin mVb[k] = mAluR; mFb[k] = 0; end
        else if (!mRb[k]) begin
          if (extValid && mTb[k] == extTag) begin mRb[k] = 1; mVb[k] = extVal; end
          else if (sel >= 0 && mTb[k] == selDst) begin mRb[k] = 1; mFb[k] = 1; end
        end
      end
    end
    if (sel >= 0) mBusy[sel] = 0;
    if (dispValid && cnt < N) begin
      for (int k = 0; k < N; k++) begin
        if (!mBusy[k]) begin
          mBusy[k] = 1; mOp[k] = dispOp; mDst[k] = dispDstTag;
          mTa[k] = dispSrcATag; mTb[k] = dispSrcBTag;
          mFa[k] = 0; mFb[k] = 0;
          mRa[k] = 1; mRb[k] = 1;
          if (dispSrcAReady) mVa[k] = dispSrcAVal;
          else if (extValid && dispSrcATag == extTag) mVa[k] = extVal;
          else if (sel >= 0 && dispSrcATag == selDst) mFa[k] = 1;
          else mRa[k] = 0;
          if (dispSrcBReady) mVb[k] = dispSrcBVal;
          else if (extValid && dispSrcBTag == extTag) mVb[k] = extVal;
          else if (sel >= 0 && dispSrcBTag == selDst) mFb[k] = 1;
          else mRb[k] = 0;
          mSeq[k] = seqNext++;
          break;
        end
      end
    end
    mAluV = (sel >= 0);
    if (sel >= 0) begin mAluT = selDst; mAluR = res; end
    cyc++;
    @(posedge clk);
    @(negedge clk);
    dispValid = 0;
    extValid = 0;
  endtask

  task automatic setDisp(bit [1:0] op, bit [5:0] dst,
                         bit ra, bit [5:0] ta, bit [31:0] va,
                         bit rb, bit [5:0] tb, bit [31:0] vb);
    dispValid = 1; dispOp = op; dispDstTag = dst;
    dispSrcAReady = ra; dispSrcATag = ta; dispSrcAVal = va;
    dispSrcBReady = rb; dispSrcBTag = tb; dispSrcBVal = vb;
  endtask

  task automatic setExt(bit [5:0] t, bit [31:0] v);
    extValid = 1; extTag = t; extVal = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int c0;
    for (int k = 0; k < N; k++) mBusy[k] = 0;
    clearLog();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(issueValid == 0, "R1 issueValid after reset", issueValid, 0);
    chk(aluValid == 0, "R1 aluValid after reset", aluValid, 0);
    chk(full == 0, "R1 full after reset", full, 0);

    // chain ADD -> SUB -> ADD released by an external value
    setDisp(2'd0, 6'd1, 0, 6'd40, 0, 1, 0, 32'd7); step();
    setDisp(2'd1, 6'd2, 0, 6'd1, 0, 1, 0, 32'd3); step();
    setDisp(2'd0, 6'd3, 0, 6'd2, 0, 0, 6'd1, 0); step();
    c0 = cyc;
    setExt(6'd40, 32'd5); step();
    idle(5);
    chk(issueCyc[1] == c0 + 1, "R7 woken by external broadcast", issueCyc[1], c0 + 1);
    chk(issueCyc[2] == issueCyc[1] + 1, "R5 back-to-back issue", issueCyc[2], issueCyc[1] + 1);
    chk(issueCyc[3] == issueCyc[2] + 1, "R5 back-to-back issue", issueCyc[3], issueCyc[2] + 1);
    chk(resVal[1] == 32'd12, "R4 add result", resVal[1], 12);
    chk(resVal[2] == 32'd9, "R6 bypassed operand", resVal[2], 9);
    chk(resVal[3] == 32'd21, "R6 captured operand", resVal[3], 21);

    // dispatch-time capture from both broadcasts
    clearLog();
    setDisp(2'd3, 6'd5, 0, 6'd41, 0, 1, 0, 32'hF0);
    setExt(6'd41, 32'h0F); step();
    idle(2);
    chk(resVal[5] == 32'hFF, "R8 external capture at dispatch", resVal[5], 32'hFF);
    setDisp(2'd0, 6'd6, 1, 0, 32'd1, 1, 0, 32'd1); step();
    setDisp(2'd1, 6'd7, 0, 6'd6, 0, 1, 0, 32'd10); step();
    idle(3);
    chk(issueCyc[7] == issueCyc[6] + 1, "R8 early capture at dispatch", issueCyc[7], issueCyc[6] + 1);
    chk(resVal[7] == 32'hFFFFFFF8, "R8 bypass after dispatch capture", resVal[7], 32'hFFFFFFF8);

    // oldest-first under contention; younger op placed in a lower slot
    clearLog();
    setDisp(2'd0, 6'd10, 0, 6'd50, 0, 1, 0, 32'd1); step();
    setDisp(2'd0, 6'd11, 0, 6'd51, 0, 1, 0, 32'd1); step();
    setDisp(2'd0, 6'd12, 0, 6'd50, 0, 1, 0, 32'd1); step();
    c0 = cyc;
    setExt(6'd51, 32'd100); step();
    step();
    chk(issueCyc[11] == c0 + 1, "R7 external wakeup timing", issueCyc[11], c0 + 1);
    setDisp(2'd0, 6'd13, 0, 6'd50, 0, 1, 0, 32'd1); step();
    setExt(6'd50, 32'd2); step();
    idle(5);
    chk(resVal[11] == 32'd101, "R7 external value", resVal[11], 101);
    chk(issueCyc[12] == issueCyc[10] + 1, "R3 age order", issueCyc[12], issueCyc[10] + 1);
    chk(issueCyc[13] == issueCyc[12] + 1, "R3 age order", issueCyc[13], issueCyc[12] + 1);

    // fill the queue, try one more, then drain
    clearLog();
    for (int i = 0; i < N; i++) begin
      setDisp(2'd2, 6'(20 + i), 0, 6'd52, 0, 1, 0, 32'hFFFF); step();
    end
    chk(full == 1, "R9 full with all slots used", full, 1);
    setDisp(2'd0, 6'd30, 1, 0, 32'd3, 1, 0, 32'd4); step();
    chk(issueValid == 0, "R2 dropped dispatch not issued", issueValid, 0);
    setExt(6'd52, 32'h1234); step();
    chk(issueValid == 1 && issueDstTag == 6'd20, "R10 first drain issue", issueDstTag, 20);
    chk(full == 1, "R9 slot still held in issue cycle", full, 1);
    step();
    chk(full == 0, "R9 full drops after issue", full, 0);
    idle(10);
    chk(issueCyc[30] == -1, "R2 stalled dispatch ignored", issueCyc[30], -1);
    for (int i = 1; i < N; i++)
      chk(issueCyc[20 + i] == issueCyc[20 + i - 1] + 1, "R10 one slot per cycle",
          issueCyc[20 + i], issueCyc[20 + i - 1] + 1);
    chk(resVal[27] == 32'h1234, "R4 and result", resVal[27], 32'h1234);

    // mixed traffic compared against the model every cycle
    begin
      bit [5:0] lastDst = 6'd1;
      bit [5:0] nextDst = 6'd1;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(1, 0) == 1) begin
          setDisp(2'($urandom_range(3, 0)), nextDst,
                  $urandom_range(2, 0) != 0, lastDst, $urandom,
                  $urandom_range(3, 0) != 0, 6'($urandom_range(63, 40)), $urandom);
          lastDst = nextDst;
          nextDst = (nextDst == 6'd39) ? 6'd1 : nextDst + 6'd1;
        end
        if ($urandom_range(3, 0) == 0) setExt(6'($urandom_range(63, 1)), $urandom);
        step();
      end
    end
    idle(4);
    summary();
  end

endmodule